// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This block sits on the host side of a solid-state line access switch. It drives the switch's two logic control lines, ring and access, and an open-drain shutdown-override line. Its job is to take a subscriber line out of power ringing and into the idle/talk state. A start pulse first places the line in ringing with the code ring=1, access=0. A later talk request, qualified by a two-bit mode select, chooses how the line leaves ringing.

In make-before-break mode the idle code (0,0) is issued at once, and the switch completes the release at its own zero crossing. Break-before-make can be done in two ways. In the first, the block issues the all-off code (1,1), holds it for a timed interval and then issues idle. In the second, the block pulls the shutdown line low while the ringing code is still applied, rewrites the control lines to idle underneath the override, and then lets the line float again.

The hold interval is counted from a one-millisecond tick and its length is a parameter (25 by default). A busy flag covers the hold, and a one-cycle done pulse marks the cycle in which the idle code takes effect.

Top module: `ring_talk_seq`

## Requirements
- R1: During and immediately after reset the control code is idle (ring=0, access=0), the shutdown line is released (sd_pull_low=0), and busy and done are 0.
- R2: A ring_start pulse sampled while the sequencer is idle sets the code to ringing (ring=1, access=0) in the next cycle. A ring_start at any other time has no effect on the outputs.
- R3: A talk_req sampled while ringing with mode_sel 0 or 3 sets the idle code in the next cycle, with done=1 in that same cycle. The all-off code and the shutdown pull are never used on this path.
- R4: With mode_sel 1, the code becomes all-off (1,1) in the cycle after talk_req, and busy rises. The code stays all-off until HOLD_MS ticks have been sampled during the hold. In the cycle after the HOLD_MS-th such tick the code is idle and done=1.
- R5: With mode_sel 2, sd_pull_low rises in the cycle after talk_req while the code is still ringing. In the following cycle the code becomes idle while the pull is still held. The pull is released, with done=1, in the cycle after HOLD_MS ticks have been sampled, counting from the first pulled cycle.
- R6: The shutdown line has only two states, pulled low (sd_pull_low=1) or released (0), and is never driven high. A pull never coincides with the all-off code.
- R7: A talk_req or ring_start arriving while busy, or a talk_req arriving while not ringing, is ignored. The mode is sampled only when a request is accepted.
- R8: busy is 1 exactly while the all-off code or the shutdown pull is in effect. done is a single-cycle pulse that appears only together with the idle code, with the line released and busy low.
- R9: The access-only code (ring=0, access=1) is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ring_start | input | 1 | Pulse: put the idle line into ringing |
| talk_req | input | 1 | Pulse: move the ringing line to idle/talk |
| mode_sel | input | 2 | 0/3 make-before-break, 1 break via all-off code, 2 break via shutdown override |
| ring_ctl | output | 1 | Ring control line to the switch |
| acc_ctl | output | 1 | Access control line to the switch |
| sd_pull_low | output | 1 | 1 enables the open-drain pull-down of the shutdown line; 0 leaves it floating |
| busy | output | 1 | A timed break-before-make hold is in progress |
| done | output | 1 | One-cycle pulse when the idle code is applied |

## Verification
The checker watches, on every cycle, the properties that hold at every cycle:
- the access-only code is never issued;
- the shutdown pull never coincides with the all-off code;
- the pull only starts from the ringing code;
- the all-off code is left only for idle;
- busy matches the hold conditions;
- done is a lone pulse that appears only with the idle code;
- the tick count of every hold equals HOLD_MS.

Only the bench's scenarios can show the rest:
- that each mode is actually chosen by its mode_sel value at acceptance;
- that requests during a hold or outside ringing really leave the outputs untouched;
- that the swap under the override comes exactly one cycle after the pull.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RING = 3'd1,
    ST_OFF  = 3'd2,
    ST_PULL = 3'd3,
    ST_SWAP = 3'd4
  } rtt_state_e;

  typedef enum logic [1:0] {
    MD_MBB     = 2'd0,
    MD_BBM_IN  = 2'd1,
    MD_BBM_OVR = 2'd2,
    MD_MBB_ALT = 2'd3
  } rtt_mode_e;

  typedef struct packed {
    logic ring;
    logic acc;
    logic pull;
    logic busy;
  } rtt_ctl_t;

  function automatic rtt_ctl_t ctl_of(rtt_state_e s);
    rtt_ctl_t c;
    c = '0;
    case (s)
      ST_RING: c.ring = 1'b1;
      ST_OFF: begin
        c.ring = 1'b1;
        c.acc  = 1'b1;
        c.busy = 1'b1;
      end
      ST_PULL: begin
        c.ring = 1'b1;
        c.pull = 1'b1;
        c.busy = 1'b1;
      end
      ST_SWAP: begin
        c.pull = 1'b1;
        c.busy = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic is_hold(rtt_state_e s);
    return (s == ST_OFF) || (s == ST_PULL) || (s == ST_SWAP);
  endfunction

endpackage

// File: rtl/rtt_hold_timer.sv
module rtt_hold_timer #(
  parameter int HOLD_MS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (HOLD_MS < 2) ? 1 : $clog2(HOLD_MS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtt_fsm.sv
module rtt_fsm
  import rtt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ring_start,
  input  logic       talk_req,
  input  logic [1:0] mode_sel,
  input  logic       expire,
  output rtt_state_e st_q,
  output rtt_state_e st_d,
  output logic       run,
  output logic       done_d
);
  rtt_mode_e mode;
  assign mode = rtt_mode_e'(mode_sel);
  assign run  = is_hold(st_q);

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (ring_start) st_d = ST_RING;
      ST_RING: begin
        if (talk_req) begin
          case (mode)
            MD_BBM_IN:  st_d = ST_OFF;
            MD_BBM_OVR: st_d = ST_PULL;
            default: begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          endcase
        end
      end
      ST_PULL: begin
        if (expire) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_SWAP;
        end
      end
      ST_OFF, ST_SWAP: begin
        if (expire) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/rtt_ctl_reg.sv
module rtt_ctl_reg
  import rtt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rtt_state_e st_d,
  input  logic       done_d,
  output logic       ring_ctl,
  output logic       acc_ctl,
  output logic       sd_pull_low,
  output logic       busy,
  output logic       done
);
  rtt_ctl_t c_d;
  assign c_d = ctl_of(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_ctl    <= 1'b0;
      acc_ctl     <= 1'b0;
      sd_pull_low <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      ring_ctl    <= c_d.ring;
      acc_ctl     <= c_d.acc;
      sd_pull_low <= c_d.pull;
      busy        <= c_d.busy;
      done        <= done_d;
    end
  end
endmodule

// File: rtl/ring_talk_seq.sv
module ring_talk_seq
  import rtt_pkg::*;
#(
  parameter int HOLD_MS = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       ring_start,
  input  logic       talk_req,
  input  logic [1:0] mode_sel,
  output logic       ring_ctl,
  output logic       acc_ctl,
  output logic       sd_pull_low,
  output logic       busy,
  output logic       done
);
  rtt_state_e st_q, st_d;
  logic run, expire, done_d;

  rtt_fsm u_fsm (
    .clk(clk), .rst(rst), .ring_start(ring_start), .talk_req(talk_req),
    .mode_sel(mode_sel), .expire(expire), .st_q(st_q), .st_d(st_d),
    .run(run), .done_d(done_d)
  );

  rtt_hold_timer #(.HOLD_MS(HOLD_MS)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .tick(ms_tick), .expire(expire)
  );

  rtt_ctl_reg u_out (
    .clk(clk), .rst(rst), .st_d(st_d), .done_d(done_d),
    .ring_ctl(ring_ctl), .acc_ctl(acc_ctl), .sd_pull_low(sd_pull_low),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/ring_talk_seq_chk.sv
module ring_talk_seq_chk #(
  parameter int HOLD_MS = 25
) (
  input logic clk,
  input logic rst,
  input logic ms_tick,
  input logic ring_ctl,
  input logic acc_ctl,
  input logic sd_pull_low,
  input logic busy,
  input logic done
);
  localparam int CW = $clog2(HOLD_MS + 2);

  logic alloff, held;
  logic [CW-1:0] hcnt;

  assign alloff = ring_ctl && acc_ctl;
  assign held   = alloff || sd_pull_low;

  always_ff @(posedge clk) begin
    if (rst || !held) hcnt <= '0;
    else if (ms_tick) hcnt <= hcnt + 1'b1;
  end

  AST_NO_ACCESS_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(acc_ctl && !ring_ctl)); // R9
  AST_PULL_NOT_ALLOFF: assert property (@(posedge clk) disable iff (rst)
    !(sd_pull_low && alloff)); // R6
  AST_PULL_FROM_RING: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_pull_low) |-> (ring_ctl && !acc_ctl)); // R5
  AST_ALLOFF_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(alloff) && !alloff) |-> (!ring_ctl && !acc_ctl && done)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ring_ctl && !acc_ctl && !sd_pull_low && !busy)); // R8
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    busy == held); // R8
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
    ($past(held) && !held) |-> (hcnt == CW'(HOLD_MS))); // R4
endmodule

bind ring_talk_seq ring_talk_seq_chk #(.HOLD_MS(HOLD_MS)) u_chk (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .ring_ctl(ring_ctl),
  .acc_ctl(acc_ctl), .sd_pull_low(sd_pull_low), .busy(busy), .done(done)
);

// File: tb/sim_ring_talk_seq.sv
module sim_ring_talk_seq;
  localparam int HOLD = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, ring_start = 1'b0, talk_req = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic ring_ctl, acc_ctl, sd_pull_low, busy, done;

  always #2 clk = ~clk;

  ring_talk_seq #(.HOLD_MS(HOLD)) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .ring_start(ring_start),
    .talk_req(talk_req), .mode_sel(mode_sel), .ring_ctl(ring_ctl),
    .acc_ctl(acc_ctl), .sd_pull_low(sd_pull_low), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  int m_st = 0, m_cnt = 0, held_ticks = 0;
  bit m_done = 0, m_ign = 0, obs_held = 0, obs_sd = 0;
  int mode_seen[4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the requirements, stepped at each rising edge.
  always @(posedge clk) begin
    m_done = 0;
    m_ign  = 0;
    if (rst) begin
      m_st = 0; m_cnt = 0;
    end else begin
      if (obs_held && ms_tick) held_ticks++;
      case (m_st)
        0: begin
          if (ring_start) m_st = 1;
          if (talk_req) m_ign = 1;
        end
        1: begin
          if (ring_start) m_ign = 1;
          if (talk_req) begin
            mode_seen[mode_sel]++;
            m_cnt = 0;
            if (mode_sel == 2'd1) m_st = 2;
            else if (mode_sel == 2'd2) m_st = 3;
            else begin m_st = 0; m_done = 1; end
          end
        end
        2, 4: begin
          if (ring_start || talk_req) m_ign = 1;
          if (ms_tick) begin
            m_cnt++;
            if (m_cnt == HOLD) begin m_st = 0; m_done = 1; end
          end
        end
        default: begin
          if (ring_start || talk_req) m_ign = 1;
          if (ms_tick) m_cnt++;
          if (m_cnt == HOLD) begin m_st = 0; m_done = 1; end
          else m_st = 4;
        end
      endcase
    end
  end

  function automatic int exp_code(int st);
    case (st)
      1, 3: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic string code_tag(int st, bit ign);
    if (ign) return "R7";
    case (st)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_checks();
    int code;
    bit now_held;
    code = {ring_ctl, acc_ctl};
    chk(code == exp_code(m_st), code_tag(m_st, m_ign), code, exp_code(m_st));
    chk(sd_pull_low == (m_st == 3 || m_st == 4), m_ign ? "R7" : "R6",
        sd_pull_low, (m_st == 3 || m_st == 4));
    chk(busy == (m_st >= 2), "R8 busy", busy, (m_st >= 2));
    chk(done == m_done, "R8 done", done, m_done);
    chk(!(acc_ctl && !ring_ctl), "R9", code, 0);
    now_held = (ring_ctl && acc_ctl) || sd_pull_low;
    if (obs_held && !now_held)
      chk(held_ticks == HOLD, obs_sd ? "R5 hold length" : "R4 hold length",
          held_ticks, HOLD);
    if (!now_held) held_ticks = 0;
    obs_held = now_held;
    obs_sd   = sd_pull_low;
  endtask

  task automatic cyc(input bit rs, input bit tr, input logic [1:0] md);
    @(negedge clk);
    do_checks();
    ring_start = rs;
    talk_req   = tr;
    mode_sel   = md;
    ms_tick    = ($urandom % 4) == 0;
  endtask

  task automatic wait_idle();
    while (m_st != 0) cyc(0, 0, 2'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ring_ctl, acc_ctl} == 0, "R1 code", {ring_ctl, acc_ctl}, 0);
    chk(sd_pull_low == 0, "R1 sd", sd_pull_low, 0);
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    rst = 1'b0;
    // Directed: each mode in turn, with requests injected during holds (R7).
    for (int m = 0; m < 4; m++) begin
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      cyc(0, 1, 2'(m));
      cyc(1, 1, 2'((m + 1) % 4));
      cyc(0, 1, 2'd0);
      wait_idle();
      cyc(0, 1, 2'd1);
      cyc(0, 0, 0);
    end
    // Random traffic.
    for (int i = 0; i < 8000; i++)
      cyc(($urandom % 16) == 0, ($urandom % 10) == 0, 2'($urandom));
    wait_idle();
    cyc(0, 0, 0);
    for (int m = 0; m < 4; m++)
      chk(mode_seen[m] > 0, "R3 R4 R5 coverage", mode_seen[m], 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule